// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the data-moving core of a memory-mapped SPI master. It owns a byte-wide transmit queue and a byte-wide receive queue (each holding up to 128 bytes by default). It runs one burst at a time on the serial pins. Before a burst, the host side sets two lengths. The total length is how many bytes the burst lasts. The transmit length is how many of those bytes come from the transmit queue. Once the transmit length is used up, the engine sends zero bytes for the rest of the burst.

A pulse on `start` launches the burst. `active` goes high and stays high until the last byte has been shifted. It then drops by itself, and the done flag is raised in the same cycle. Clock phase, clock polarity and bit order are fixed for the whole burst, taken when the burst starts. Received bytes can be kept out of the receive queue while the transmit phase runs. If a byte arrives while the receive queue is full, that byte is dropped and the overflow flag is set. Chip-select lines either follow the burst automatically or follow a level chosen by software.

Both queues face the host through valid/ready streams. On the transmit side, a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the queue is full, and the data must be held until it is taken. On the receive side, `rx_valid` is high while the queue holds a byte, and `rx_data` shows the oldest byte. That byte stays in place until an edge where `rx_ready` is high.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, the following hold:
  - `active`, `done_flag`, `ovf_flag`, `irq`, `rx_valid` and both levels are 0, and `tx_ready` is 1.
  - `sclk` equals `cfg_cpol`.
  - Every chip-select line is at its inactive level.
- R2: A `start` pulse while idle raises `active` on the next edge. `active` drops by itself after the last byte, and `done_flag` is set in the same cycle. A `start` pulse while `active` is high is ignored, along with any new lengths.
- R3: A burst shifts exactly `burst_len` bytes. Byte k (counting from 0) is taken from the transmit queue when k < `tx_len`, and is 0x00 otherwise. With `tx_len` = 0, every byte is 0x00.
- R4: `sclk` idles at `cfg_cpol`.
  - With `cfg_cpha` = 0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge.
  - With `cfg_cpha` = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With `cfg_lsb_first` = 1, bit 0 of each byte goes first in both directions. With `cfg_lsb_first` = 0, bit 7 goes first.
- R6: Every received byte is written to the receive queue, in order, with one exception. When `cfg_discard` = 1, the bytes received during the first `tx_len` bytes of the burst are not written.
- R7: A byte that arrives while the receive queue holds 128 bytes is dropped, and `ovf_flag` is set.
- R8: Both flags are cleared by a one-cycle pulse on their clear input. A set and a clear in the same cycle leave the flag set. `irq` is high while an enabled flag is set.
- R9: Chip selects behave as follows.
  - `cfg_cs_active_high` = 0 means active low.
  - Lines not named by `cfg_cs_sel` stay inactive.
  - With `cfg_cs_manual` = 1, the selected line equals `cfg_cs_level`.
  - Otherwise, the selected line is active exactly while `active` is high.
- R10: The queues follow the stream rules above.
  - `tx_level` and `rx_level` report their fill.
  - `tx_ready` is 0 when the transmit queue is full, and a push then has no effect.
  - A pulse on `tx_flush` or `rx_flush` empties that queue.
- R11: During the transmit phase, if the transmit queue is empty, the engine waits with `sclk` idle. It resumes when a byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpha | input | 1 | Clock phase, taken at start |
| cfg_cpol | input | 1 | Clock idle level, taken at start |
| cfg_lsb_first | input | 1 | Bit order, taken at start |
| cfg_discard | input | 1 | Drop received bytes during the transmit phase |
| cfg_cs_active_high | input | 1 | Chip-select active level |
| cfg_cs_sel | input | 2 | Selected chip-select line |
| cfg_cs_manual | input | 1 | Selected line follows `cfg_cs_level` |
| cfg_cs_level | input | 1 | Manual chip-select level |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes taken from the transmit queue |
| start | input | 1 | Launch pulse |
| active | output | 1 | Burst in progress; clears itself at the end |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit queue not full |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive byte available |
| rx_ready | input | 1 | Host takes the receive byte |
| rx_data | output | 8 | Oldest received byte |
| tx_level | output | 8 | Transmit queue fill |
| rx_level | output | 8 | Receive queue fill |
| irq_en_done | input | 1 | Interrupt enable for the done flag |
| irq_en_ovf | input | 1 | Interrupt enable for the overflow flag |
| clr_done | input | 1 | Clear pulse for the done flag |
| clr_ovf | input | 1 | Clear pulse for the overflow flag |
| done_flag | output | 1 | Burst finished |
| ovf_flag | output | 1 | Receive byte dropped |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |

## Verification
`active` is due one edge after `start`. Each byte then takes 16 half-periods of `sclk` plus two cycles of control, and `done_flag` rises on the same edge that `active` falls. A flag clear, a flush or a queue push is visible one edge after its pulse. The bench therefore drives each input at a falling edge and reads the result at the next falling edge. For a whole burst, it waits for `active` to fall under a cycle limit, and only then compares the bit stream captured by its serial slave model, the queue levels and the flags. The slave model shifts and samples on the edges that R4 and R5 prescribe, so any error in phase or bit order shows up as a wrong byte.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_NEXT  = 2'd1,
    ENG_SHIFT = 2'd2
  } eng_state_t;

  function automatic logic [BYTE_W-1:0] flip_bits(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign push_ok = push && (cnt != CW'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rptr];
  assign count = cnt;

  // R10: an accepted push without a pop grows the fill by exactly one
  assert_fifo_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !flush) |=> (count == $past(count) + CW'(1)));

  // R10: the head entry is held while nobody pops it
  assert_fifo_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop && !flush) |=> $stable(rdata));
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
  import spi_burst_pkg::*;
#(
  parameter int unsigned HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned EW = $clog2(2 * BYTE_W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * BYTE_W - 1);

  logic [TW-1:0]     timer;
  logic [EW-1:0]     edge_n;
  logic              sclk_q, mosi_q, busy_q, done_q;
  logic [BYTE_W-1:0] tx_sr, rx_sr, ordered;
  logic              tick, leading, sample_now, drive_now;

  assign tick       = busy_q && (timer == TW'(HALF - 1));
  assign leading    = ~edge_n[0];
  assign sample_now = leading ^ cpha;
  assign drive_now  = cpha ? leading : (~leading && (edge_n != LAST_EDGE));
  assign ordered    = lsb_first ? flip_bits(load_byte) : load_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer  <= '0;
      edge_n <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        timer  <= '0;
        edge_n <= '0;
        sclk_q <= cpol;
        if (!cpha) begin
          mosi_q <= ordered[BYTE_W-1];
          tx_sr  <= {ordered[BYTE_W-2:0], 1'b0};
        end else begin
          tx_sr  <= ordered;
        end
      end else if (tick) begin
        timer  <= '0;
        sclk_q <= ~sclk_q;
        edge_n <= edge_n + EW'(1);
        if (sample_now) rx_sr <= {rx_sr[BYTE_W-2:0], miso};
        if (drive_now) begin
          mosi_q <= tx_sr[BYTE_W-1];
          tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
        if (edge_n == LAST_EDGE) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        timer <= timer + TW'(1);
      end
    end
  end

  assign sclk      = busy_q ? sclk_q : cpol;
  assign mosi      = mosi_q;
  assign active    = busy_q;
  assign byte_done = done_q;
  assign rx_byte   = lsb_first ? flip_bits(rx_sr) : rx_sr;

  // R4: after an even number of toggles a byte leaves the clock at its idle level
  assert_byte_ends_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (sclk_q == cpol));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 128,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned HALF_PERIOD = 2,
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic              cfg_lsb_first,
  input  logic              cfg_discard,
  input  logic              cfg_cs_active_high,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic              cfg_cs_manual,
  input  logic              cfg_cs_level,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              start,
  output logic              active,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic [LVL_W-1:0]  tx_level,
  output logic [LVL_W-1:0]  rx_level,
  input  logic              irq_en_done,
  input  logic              irq_en_ovf,
  input  logic              clr_done,
  input  logic              clr_ovf,
  output logic              done_flag,
  output logic              ovf_flag,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_line
);
  eng_state_t        st;
  logic              busy;
  logic [CNT_W-1:0]  idx, total_q, txlen_q;
  logic              cpha_q, cpol_q, lsb_q, disc_q;
  logic              done_q, ovf_q;

  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] tx_head, sh_byte, sh_rx;
  logic              tx_pop, rx_push, sh_load, sh_done, sh_active, sh_sclk, sh_mosi;
  logic              at_end, in_tx, want_tx, finish, step_done;

  assign at_end    = (idx == total_q);
  assign in_tx     = (idx < txlen_q);
  assign want_tx   = (st == ENG_NEXT) && !at_end && in_tx;
  assign tx_pop    = want_tx && !tx_empty;
  assign sh_load   = tx_pop || ((st == ENG_NEXT) && !at_end && !in_tx);
  assign sh_byte   = in_tx ? tx_head : '0;
  assign finish    = (st == ENG_NEXT) && at_end;
  assign step_done = (st == ENG_SHIFT) && sh_done;
  assign rx_push   = step_done && !(disc_q && in_tx);

  spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_valid), .wdata(tx_data), .full(tx_full),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .count(tx_level)
  );

  spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(sh_rx), .full(rx_full),
    .pop(rx_ready), .rdata(rx_data), .empty(rx_empty), .count(rx_level)
  );

  spi_burst_shifter #(.HALF(HALF_PERIOD)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_byte(sh_byte),
    .cpha(cpha_q), .cpol(cpol_q), .lsb_first(lsb_q), .miso(miso),
    .sclk(sh_sclk), .mosi(sh_mosi), .active(sh_active),
    .byte_done(sh_done), .rx_byte(sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      busy    <= 1'b0;
      idx     <= '0;
      total_q <= '0;
      txlen_q <= '0;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      lsb_q   <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: if (start) begin
          busy    <= 1'b1;
          idx     <= '0;
          total_q <= burst_len;
          txlen_q <= tx_len;
          cpha_q  <= cfg_cpha;
          cpol_q  <= cfg_cpol;
          lsb_q   <= cfg_lsb_first;
          disc_q  <= cfg_discard;
          st      <= ENG_NEXT;
        end
        ENG_NEXT: begin
          if (finish) begin
            busy <= 1'b0;
            st   <= ENG_IDLE;
          end else if (sh_load) begin
            st <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: if (sh_done) begin
          idx <= idx + CNT_W'(1);
          st  <= ENG_NEXT;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (finish)        done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (rx_push && rx_full) ovf_q <= 1'b1;
      else if (clr_ovf)       ovf_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_line[g] = (cfg_cs_sel == SEL_W'(g))
                        ? (cfg_cs_manual ? cfg_cs_level
                                         : (busy ? cfg_cs_active_high : ~cfg_cs_active_high))
                        : ~cfg_cs_active_high;
  end

  assign active    = busy;
  assign tx_ready  = !tx_full;
  assign rx_valid  = !rx_empty;
  assign done_flag = done_q;
  assign ovf_flag  = ovf_q;
  assign irq       = (done_q & irq_en_done) | (ovf_q & irq_en_ovf);
  assign sclk      = busy ? sh_sclk : cfg_cpol;
  assign mosi      = busy ? sh_mosi : 1'b0;

  // R2: the burst never ends without raising the done flag
  assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R7: a byte refused by a full receive queue leaves the overflow flag set
  assert_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovf_flag);

  // R9: in automatic mode exactly one line is active during a burst
  assert_cs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_cs_manual) |-> ($countones(cs_line ^ {NUM_CS{~cfg_cs_active_high}}) == 1));

  // R11: a starved transmit phase does not move the serial clock
  assert_stall_holds_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (want_tx && tx_empty) |=> $stable(sclk));

  // R3: the shifter is never reloaded while a byte is still in flight
  assert_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !sh_load);
endmodule

// File: tb/spi_burst_engine_tb_top.sv
module spi_burst_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpha = 0, cfg_cpol = 0, cfg_lsb_first = 0, cfg_discard = 0;
  logic cfg_cs_active_high = 0, cfg_cs_manual = 0, cfg_cs_level = 0;
  logic [1:0] cfg_cs_sel = 0;
  logic [23:0] burst_len = 0, tx_len = 0;
  logic start = 0, active, tx_flush = 0, rx_flush = 0;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [7:0] tx_data = 0, rx_data, tx_level, rx_level;
  logic irq_en_done = 0, irq_en_ovf = 0, clr_done = 0, clr_ovf = 0;
  logic done_flag, ovf_flag, irq, sclk, mosi, miso;
  logic [3:0] cs_line;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
    .cfg_lsb_first(cfg_lsb_first), .cfg_discard(cfg_discard),
    .cfg_cs_active_high(cfg_cs_active_high), .cfg_cs_sel(cfg_cs_sel),
    .cfg_cs_manual(cfg_cs_manual), .cfg_cs_level(cfg_cs_level),
    .burst_len(burst_len), .tx_len(tx_len), .start(start), .active(active),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_level(tx_level), .rx_level(rx_level), .irq_en_done(irq_en_done),
    .irq_en_ovf(irq_en_ovf), .clr_done(clr_done), .clr_ovf(clr_ovf),
    .done_flag(done_flag), .ovf_flag(ovf_flag), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_line(cs_line)
  );

  // ---------------- serial slave model ----------------
  logic [7:0] cap [256];
  logic [7:0] s_salt = 8'h3C;
  int s_bits = 0, s_drv = 0;
  logic s_prev = 1'b0, s_clear = 1'b0;

  function automatic logic [7:0] resp(input int k, input logic [7:0] salt);
    return 8'(k * 53 + 17) ^ salt;
  endfunction

  function automatic logic slave_bit(input int n, input logic [7:0] salt, input logic lsb);
    logic [7:0] b;
    int j;
    if (n < 0) return 1'b0;
    b = resp(n / 8, salt);
    j = n % 8;
    return lsb ? b[j] : b[7 - j];
  endfunction

  assign miso = slave_bit(s_drv, s_salt, cfg_lsb_first);

  always @(negedge clk) begin
    if (s_clear) begin
      s_bits = 0;
      s_drv  = cfg_cpha ? -1 : 0;
      s_prev = cfg_cpol;
    end else if (sclk !== s_prev) begin
      if ((s_prev == cfg_cpol) ^ cfg_cpha) begin
        if (s_bits / 8 < 256) cap[s_bits / 8][cfg_lsb_first ? (s_bits % 8) : (7 - s_bits % 8)] = mosi;
        s_bits = s_bits + 1;
      end else begin
        s_drv = s_drv + 1;
      end
      s_prev = sclk;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clr_done = 1'b1;
    clr_ovf  = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    clr_ovf  = 1'b0;
  endtask

  task automatic slave_reset();
    @(negedge clk);
    s_clear = 1'b1;
    @(negedge clk);
    @(negedge clk);
    s_clear = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    int t = 0;
    while (active && t < limit) begin
      @(negedge clk);
      t++;
    end
    chk(!active, "R2 burst finishes in time", active, 0);
  endtask

  // runs one burst and checks serial bytes, flags and receive queue
  task automatic run_burst(input int total, input int txl, input bit disc, input bit cpha,
                           input bit cpol, input bit lsb, input bit stall, input bit drain,
                           input string tag);
    logic [7:0] txb [128];
    int n_elig, n_exp, got;
    for (int k = 0; k < txl; k++) txb[k] = 8'($urandom);
    cfg_cpha = cpha; cfg_cpol = cpol; cfg_lsb_first = lsb; cfg_discard = disc;
    burst_len = 24'(total); tx_len = 24'(txl);
    s_salt = 8'($urandom);
    pulse_clear();
    chk(done_flag == 0 && ovf_flag == 0, "R8 flags cleared by pulse", {done_flag, ovf_flag}, 0);
    slave_reset();
    chk(sclk == cpol, "R4 clock idles at polarity", sclk, cpol);
    if (!stall) for (int k = 0; k < txl; k++) push_byte(txb[k]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(active == 1, "R2 active one edge after start", active, 1);
    if (stall) begin
      repeat (40) @(negedge clk);
      chk(active == 1, "R11 waits for transmit data", active, 1);
      chk(s_bits == 0, "R11 no clock edges while starved", s_bits, 0);
      chk(cs_line == (4'b1111 & ~(4'b0001 << cfg_cs_sel)), "R9 automatic select during burst",
          cs_line, 4'b1111 & ~(4'b0001 << cfg_cs_sel));
      burst_len = 24'(total + 6);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      burst_len = 24'(total);
      for (int k = 0; k < txl; k++) push_byte(txb[k]);
    end
    wait_idle(total * (16 * 2 + 4) + 200);
    chk(s_bits == total * 8, {tag, " R3 bit count on the wire"}, s_bits, total * 8);
    for (int k = 0; k < total && k < 256; k++) begin
      logic [7:0] e;
      e = (k < txl) ? txb[k] : 8'h00;
      chk(cap[k] == e, {tag, " R3 MOSI byte content"}, cap[k], e);
    end
    chk(done_flag == 1, "R2 done flag at end", done_flag, 1);
    n_elig = 0;
    for (int k = 0; k < total; k++) if (!(disc && k < txl)) n_elig++;
    n_exp = (n_elig > DEPTH) ? DEPTH : n_elig;
    chk(rx_level == 8'(n_exp), {tag, " R6 receive fill"}, rx_level, n_exp);
    chk(ovf_flag == (n_elig > DEPTH), "R7 overflow flag", ovf_flag, n_elig > DEPTH);
    if (drain) begin
      got = 0;
      for (int k = 0; k < total && got < n_exp; k++) begin
        if (!(disc && k < txl)) begin
          chk(rx_valid == 1, "R10 receive byte offered", rx_valid, 1);
          chk(rx_data == resp(k, s_salt), {tag, " R6 R5 received byte"}, rx_data, resp(k, s_salt));
          rx_ready = 1'b1;
          @(negedge clk);
          rx_ready = 1'b0;
          got++;
        end
      end
      chk(rx_valid == 0, "R10 receive queue empty after drain", rx_valid, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20250611);
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is held and after release
    chk(active == 0 && done_flag == 0 && ovf_flag == 0 && irq == 0, "R1 control outputs", active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_level == 0 && rx_level == 0 && rx_valid == 0, "R1 queues empty", tx_level, 0);
    chk(tx_ready == 1, "R1 transmit ready", tx_ready, 1);
    chk(cs_line == 4'b1111, "R1 chip selects inactive", cs_line, 4'b1111);
    chk(sclk == 0, "R1 clock at polarity", sclk, 0);

    // R4 R5 all four modes, both orders
    run_burst(4, 4, 0, 0, 0, 0, 0, 1, "R4 mode0");
    run_burst(4, 3, 0, 1, 0, 0, 0, 1, "R4 mode1");
    run_burst(5, 5, 0, 0, 1, 1, 0, 1, "R4 R5 mode2 lsb");
    run_burst(3, 2, 0, 1, 1, 1, 0, 1, "R4 R5 mode3 lsb");
    // R3 all dummies
    run_burst(5, 0, 0, 0, 0, 0, 0, 1, "R3 zero tx_len");
    // R6 discard during transmit phase
    run_burst(6, 4, 1, 1, 0, 0, 0, 1, "R6 discard");

    // R8 interrupt masking with done flag left set
    irq_en_done = 1'b0;
    @(negedge clk);
    chk(irq == 0, "R8 masked flag gives no irq", irq, 0);
    irq_en_done = 1'b1;
    @(negedge clk);
    chk(irq == 1, "R8 enabled flag raises irq", irq, 1);
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    chk(done_flag == 0 && irq == 0, "R8 clear pulse drops flag and irq", {done_flag, irq}, 0);
    irq_en_done = 1'b0;

    // R11 R2 R9 stall, ignored restart, automatic chip select
    cfg_cs_sel = 2'd1;
    run_burst(3, 3, 0, 0, 0, 0, 1, 1, "R11 stall");
    chk(cs_line == 4'b1111, "R9 select released after burst", cs_line, 4'b1111);

    // R9 manual chip select
    cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd2; cfg_cs_level = 1'b0;
    @(negedge clk);
    chk(cs_line == 4'b1011, "R9 manual low level", cs_line, 4'b1011);
    cfg_cs_active_high = 1'b1; cfg_cs_level = 1'b1;
    @(negedge clk);
    chk(cs_line == 4'b0100, "R9 manual high level, others inactive", cs_line, 4'b0100);
    cfg_cs_manual = 1'b0; cfg_cs_active_high = 1'b0; cfg_cs_sel = 2'd0;

    // R10 transmit queue fill, full and flush
    for (int k = 0; k < 5; k++) push_byte(8'(k));
    chk(tx_level == 5, "R10 transmit fill", tx_level, 5);
    @(negedge clk); tx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0;
    chk(tx_level == 0, "R10 transmit flush", tx_level, 0);
    for (int k = 0; k < DEPTH; k++) push_byte(8'(k));
    chk(tx_ready == 0, "R10 ready low when full", tx_ready, 0);
    push_byte(8'hEE);
    chk(tx_level == 8'(DEPTH), "R10 push into full queue has no effect", tx_level, DEPTH);
    @(negedge clk); tx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0;
    chk(tx_ready == 1 && tx_level == 0, "R10 flush frees queue", tx_level, 0);

    // R7 overflow, then R10 head hold and receive flush
    irq_en_ovf = 1'b1;
    run_burst(DEPTH + 2, 0, 0, 0, 0, 0, 0, 0, "R7 overflow");
    chk(irq == 1, "R8 overflow irq enabled", irq, 1);
    begin
      logic [7:0] d0;
      d0 = rx_data;
      repeat (3) @(negedge clk);
      chk(rx_valid == 1 && rx_data == d0, "R10 head held without ready", rx_data, d0);
      chk(d0 == resp(0, s_salt), "R7 oldest byte kept, newest dropped", d0, resp(0, s_salt));
    end
    @(negedge clk); rx_flush = 1'b1;
    @(negedge clk); rx_flush = 1'b0;
    chk(rx_level == 0 && rx_valid == 0, "R10 receive flush", rx_level, 0);
    irq_en_ovf = 1'b0;

    // constrained random bursts
    for (int t = 0; t < 8; t++) begin
      int tot, txl;
      tot = 1 + int'($urandom % 20);
      txl = int'($urandom % (tot + 3));
      run_burst(tot, txl, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 0, 1, "R3 random");
    end

    finish_run();
  end
endmodule